// File: doc/BRIEF.md
# Operand Addressing Mode Sequencer

This block turns one 6-bit operand specifier into an operand location for a 16-bit machine with eight general registers. The specifier has a 3-bit mode field and a 3-bit register field. Register 6 is the stack pointer and register 7 is the program counter. The sequencer reads and writes the register file through one read port and one write port. It issues word reads on a request/ready memory port. It ends in one of two ways: with a report that the operand is a register, or with a final 16-bit effective address. Any increment or decrement the mode calls for is applied to the register on the way.

The instruction decoder pulses `start` together with the specifier and the byte/word flag. It then waits for `done`, which carries the result for one cycle. Register 7 is expected to hold the address of the word that follows the instruction. The sequencer advances register 7 whenever it consumes an index word. Because of this, a PC-relative sum comes out as the instruction address plus 4 plus the offset. The sequencer does not fetch the data operand itself and does not write back any result.

Top module: `opnd_seq`

## Requirements
- R1: Mode 0 finishes with `is_reg`=1 and `ea` equal to the register number zero-extended. It makes no memory request and no register write.
- R2: Mode 1 finishes with `ea` equal to the register contents and leaves the register unchanged.
- R3: Mode 2 returns the old register contents as `ea` and then adds the step to the register. Mode 4 subtracts the step first and returns the new value as `ea`.
- R4: The step is 2 for word operands and 1 for byte operands. Registers 6 and 7 always step by 2, and modes 3 and 5 always step by 2.
- R5: Modes 3 and 5 update the register the way modes 2 and 4 do. They make exactly one memory read at the pointer (the old contents for mode 3, the decremented contents for mode 5), and the word read becomes `ea`.
- R6: Modes 6 and 7 read the index word at the address in register 7 and then add 2 to register 7. The sum of the base register and the index word is `ea` for mode 6. For mode 7 the sequencer reads one more word at that sum, and that word is `ea`. When the base is register 7, the advanced value is used.
- R7: With register 7 as base, mode 2 gives `ea` equal to the address of the word after the instruction and adds 2 to register 7 even for byte operands. Mode 3 gives the word stored there.
- R8: All register and address arithmetic wraps modulo 2^16.
- R9: `done` is high for exactly one cycle per accepted specifier. `ea` and `is_reg` are valid in that cycle, and `busy` is high from the cycle after `start` until `done`.
- R10: `mem_req` stays high with `mem_addr` unchanged until `mem_ready`. Read data is taken in the cycle `mem_ready` is high.
- R11: `start` is ignored while `busy` is high. The specifier in progress finishes with its own result.
- R12: Only the named register is written, plus register 7 in modes 6 and 7. All other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Accept a specifier (honoured only when idle) |
| spec_mode | input | 3 | Addressing mode field |
| spec_reg | input | 3 | Register field |
| byte_op | input | 1 | 1 = byte-sized operand |
| busy | output | 1 | A specifier is being resolved |
| done | output | 1 | One-cycle result strobe |
| is_reg | output | 1 | Operand is a register (mode 0) |
| ea | output | 16 | Effective address, or register number when `is_reg` |
| rf_raddr | output | 3 | Register file read address |
| rf_rdata | input | 16 | Register file read data (same cycle) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 3 | Register file write address |
| rf_wdata | output | 16 | Register file write data |
| mem_req | output | 1 | Memory word read request |
| mem_addr | output | 16 | Memory read address |
| mem_ready | input | 1 | Read data valid, request complete |
| mem_rdata | input | 16 | Memory read data |

## Verification
A wrong state decode shows at the ports within the same specifier, in one of three ways: the wrong number of memory reads before `done`, a `done` that never arrives, or a register value that is off by one step. A wrong step or adder direction shows up in the register file contents when `done` fires. It also shows up in `ea` for the pre-decrement modes. A lost or doubled update to register 7 moves every later PC-relative address by 2. For that reason the bench checks register 7 after every specifier. It also checks the other registers, to catch stray writes.

// File: rtl/opnd_seq_pkg.sv
package opnd_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_EVAL,
      ST_IDX,
      ST_SUM,
      ST_IND,
      ST_FIN
   } seq_state_e;

   localparam logic [2:0] AM_DIRECT   = 3'd0;
   localparam logic [2:0] AM_INDIR    = 3'd1;
   localparam logic [2:0] AM_POSTINC  = 3'd2;
   localparam logic [2:0] AM_POSTINCD = 3'd3;
   localparam logic [2:0] AM_PREDEC   = 3'd4;
   localparam logic [2:0] AM_PREDECD  = 3'd5;
   localparam logic [2:0] AM_INDEX    = 3'd6;
   localparam logic [2:0] AM_INDEXD   = 3'd7;

endpackage

// File: rtl/opnd_addsub.sv
module opnd_addsub #(
   parameter int W      = 16,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   output logic [W-1:0] y
);

   logic [W-1:0] bx;
   assign bx = b ^ {W{sub}};

   generate
      if (W < 2) begin : g_bad_width
         $error("opnd_addsub: W must be at least 2");
      end
      if (RIPPLE) begin : g_ripple
         logic [W-1:0] cy;
         assign cy[0] = sub;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign y[i] = a[i] ^ bx[i] ^ cy[i];
            if (i < W - 1) begin : g_carry
               assign cy[i+1] = (a[i] & bx[i]) | (cy[i] & (a[i] ^ bx[i]));
            end
         end
      end else begin : g_native
         assign y = a + bx + {{(W-1){1'b0}}, sub};
      end
   endgenerate

endmodule

// File: rtl/opnd_step.sv
module opnd_step #(
   parameter int W         = 16,
   parameter int REG_AW    = 3,
   parameter int WORD_STEP = 2,
   parameter int BYTE_STEP = 1,
   parameter int SP_IDX    = 6,
   parameter int PC_IDX    = 7
) (
   input  logic              byte_op,
   input  logic              deferred,
   input  logic [REG_AW-1:0] reg_sel,
   output logic [W-1:0]      step
);

   localparam logic [REG_AW-1:0] SP_A = REG_AW'(SP_IDX);
   localparam logic [REG_AW-1:0] PC_A = REG_AW'(PC_IDX);
   localparam logic [W-1:0]      WSTEP = W'(WORD_STEP);
   localparam logic [W-1:0]      BSTEP = W'(BYTE_STEP);

   generate
      if (WORD_STEP % 2 != 0) begin : g_bad_word
         $error("opnd_step: WORD_STEP must be even");
      end
      if (BYTE_STEP < 1 || BYTE_STEP > WORD_STEP) begin : g_bad_byte
         $error("opnd_step: BYTE_STEP out of range");
      end
   endgenerate

   logic wide;
   assign wide = !byte_op || deferred || (reg_sel == SP_A) || (reg_sel == PC_A);
   assign step = wide ? WSTEP : BSTEP;

endmodule

// File: rtl/opnd_ctrl.sv
module opnd_ctrl
   import opnd_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [2:0] mode_q,
   input  logic       mem_ready,
   output seq_state_e state
);

   seq_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE: if (start) nxt = ST_EVAL;
         ST_EVAL: begin
            unique case (mode_q)
               AM_POSTINCD, AM_PREDECD: nxt = ST_IND;
               AM_INDEX, AM_INDEXD:     nxt = ST_IDX;
               default:                 nxt = ST_FIN;
            endcase
         end
         ST_IDX:  if (mem_ready) nxt = ST_SUM;
         ST_SUM:  nxt = mode_q[0] ? ST_IND : ST_FIN;
         ST_IND:  if (mem_ready) nxt = ST_FIN;
         ST_FIN:  nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   // R9: the result strobe state lasts one cycle
   p_fin_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_FIN |=> state == ST_IDLE);

   // R10: a stalled deferred read keeps waiting
   p_ind_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IND && !mem_ready) |=> state == ST_IND);

   // R10: a stalled index fetch keeps waiting
   p_idx_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDX && !mem_ready) |=> state == ST_IDX);

endmodule

// File: rtl/opnd_seq.sv
module opnd_seq
   import opnd_seq_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int REG_AW     = 3,
   parameter int SP_IDX     = 6,
   parameter int PC_IDX     = 7,
   parameter int WORD_STEP  = 2,
   parameter int BYTE_STEP  = 1,
   parameter bit RIPPLE_ADD = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        spec_mode,
   input  logic [REG_AW-1:0] spec_reg,
   input  logic              byte_op,
   output logic              busy,
   output logic              done,
   output logic              is_reg,
   output logic [DATA_W-1:0] ea,
   output logic [REG_AW-1:0] rf_raddr,
   input  logic [DATA_W-1:0] rf_rdata,
   output logic              rf_we,
   output logic [REG_AW-1:0] rf_waddr,
   output logic [DATA_W-1:0] rf_wdata,
   output logic              mem_req,
   output logic [DATA_W-1:0] mem_addr,
   input  logic              mem_ready,
   input  logic [DATA_W-1:0] mem_rdata
);

   localparam logic [REG_AW-1:0] SP_A  = REG_AW'(SP_IDX);
   localparam logic [REG_AW-1:0] PC_A  = REG_AW'(PC_IDX);
   localparam logic [DATA_W-1:0] WSTEP = DATA_W'(WORD_STEP);
   localparam int                NREG  = 1 << REG_AW;

   generate
      if (DATA_W < 8 || REG_AW < 3) begin : g_bad_dims
         $error("opnd_seq: DATA_W >= 8 and REG_AW >= 3 required");
      end
      if (SP_IDX >= NREG || PC_IDX >= NREG || SP_IDX == PC_IDX) begin : g_bad_idx
         $error("opnd_seq: SP_IDX/PC_IDX invalid");
      end
   endgenerate

   seq_state_e        state;
   logic [2:0]        mode_q;
   logic [REG_AW-1:0] reg_q;
   logic              byte_q;
   logic [DATA_W-1:0] ptr_q, idx_q, ea_q;
   logic              is_reg_q;
   logic [DATA_W-1:0] step, step_sel, adj_y, sum_y;
   logic              adj_sub;
   logic              accept;

   assign accept = (state == ST_IDLE) && start;

   opnd_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .mode_q    (mode_q),
      .mem_ready (mem_ready),
      .state     (state)
   );

   opnd_step #(
      .W(DATA_W), .REG_AW(REG_AW), .WORD_STEP(WORD_STEP),
      .BYTE_STEP(BYTE_STEP), .SP_IDX(SP_IDX), .PC_IDX(PC_IDX)
   ) u_step (
      .byte_op  (byte_q),
      .deferred (mode_q[0]),
      .reg_sel  (reg_q),
      .step     (step)
   );

   // Increment/decrement path: register steps and the PC advance
   assign step_sel = (state == ST_IDX) ? WSTEP : step;
   assign adj_sub  = (state == ST_EVAL) && mode_q[2];

   opnd_addsub #(.W(DATA_W), .RIPPLE(RIPPLE_ADD)) u_adj (
      .a   (rf_rdata),
      .b   (step_sel),
      .sub (adj_sub),
      .y   (adj_y)
   );

   // Index path: base register plus fetched index word
   opnd_addsub #(.W(DATA_W), .RIPPLE(RIPPLE_ADD)) u_idx (
      .a   (rf_rdata),
      .b   (idx_q),
      .sub (1'b0),
      .y   (sum_y)
   );

   // Specifier capture
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= AM_DIRECT;
         reg_q  <= '0;
         byte_q <= 1'b0;
      end else if (accept) begin
         mode_q <= spec_mode;
         reg_q  <= spec_reg;
         byte_q <= byte_op;
      end
   end

   // Datapath registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q    <= '0;
         idx_q    <= '0;
         ea_q     <= '0;
         is_reg_q <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: if (start) is_reg_q <= 1'b0;
            ST_EVAL: begin
               unique case (mode_q)
                  AM_DIRECT: begin
                     ea_q     <= {{(DATA_W-REG_AW){1'b0}}, reg_q};
                     is_reg_q <= 1'b1;
                  end
                  AM_INDIR, AM_POSTINC: ea_q  <= rf_rdata;
                  AM_POSTINCD:          ptr_q <= rf_rdata;
                  AM_PREDEC:            ea_q  <= adj_y;
                  AM_PREDECD:           ptr_q <= adj_y;
                  default: ;
               endcase
            end
            ST_IDX: if (mem_ready) idx_q <= mem_rdata;
            ST_SUM: begin
               if (mode_q[0]) ptr_q <= sum_y;
               else           ea_q  <= sum_y;
            end
            ST_IND: if (mem_ready) ea_q <= mem_rdata;
            default: ;
         endcase
      end
   end

   // Register file port
   assign rf_raddr = (state == ST_IDX) ? PC_A : reg_q;
   assign rf_waddr = (state == ST_IDX) ? PC_A : reg_q;
   assign rf_wdata = adj_y;
   assign rf_we    = ((state == ST_EVAL) && (mode_q[2] ^ mode_q[1]))
                   || ((state == ST_IDX) && mem_ready);

   // Memory port
   assign mem_req  = (state == ST_IDX) || (state == ST_IND);
   assign mem_addr = (state == ST_IDX) ? rf_rdata : ptr_q;

   // Result
   assign busy   = (state != ST_IDLE);
   assign done   = (state == ST_FIN);
   assign is_reg = is_reg_q;
   assign ea     = ea_q;

   // R1: register mode touches neither memory nor registers
   p_direct_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && mode_q == AM_DIRECT) |-> (!mem_req && !rf_we));

   // R2: register-indirect result equals the contents read while evaluating
   p_indir_ea_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && mode_q == AM_INDIR && $past(state == ST_EVAL)) |-> ea == $past(rf_rdata));

   // R4: stack pointer and program counter keep their parity
   p_even_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_we && (rf_waddr == SP_A || rf_waddr == PC_A)) |-> rf_wdata[0] == rf_rdata[0]);

   // R10: a pending request holds its address
   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

   // R11: the captured specifier cannot change mid-sequence
   p_spec_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> ($stable(mode_q) && $stable(reg_q) && $stable(byte_q)));

   // R12: no register write in the result cycle
   p_no_write_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !rf_we);

endmodule

// File: tb/opnd_seq_tb.sv
`timescale 1ns/1ps
module opnd_seq_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  spec_mode = '0;
   logic [2:0]  spec_reg = '0;
   logic        byte_op = 1'b0;
   logic        busy, done, is_reg;
   logic [15:0] ea;
   logic [2:0]  rf_raddr, rf_waddr;
   logic [15:0] rf_rdata, rf_wdata;
   logic        rf_we;
   logic        mem_req, mem_ready;
   logic [15:0] mem_addr, mem_rdata;

   int tests = 0;
   int fails = 0;

   always #5 clk = ~clk;

   opnd_seq u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .spec_mode(spec_mode),
      .spec_reg(spec_reg), .byte_op(byte_op), .busy(busy), .done(done),
      .is_reg(is_reg), .ea(ea), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
      .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
      .mem_rdata(mem_rdata)
   );

   // Register file model
   logic [15:0] regs [8];
   logic [15:0] init_vals [8];
   logic        init_req = 1'b0;
   always @(posedge clk) begin
      if (init_req) begin
         for (int k = 0; k < 8; k++) regs[k] <= init_vals[k];
      end else if (rf_we) begin
         regs[rf_waddr] <= rf_wdata;
      end
   end
   assign rf_rdata = regs[rf_raddr];

   // Memory model: word at address a holds a + 0x0100
   int lat = 0;
   int wait_cnt = 0;
   assign mem_ready = mem_req && (wait_cnt >= lat);
   assign mem_rdata = mem_addr + 16'h0100;
   always @(posedge clk) begin
      if (!mem_req || mem_ready) wait_cnt <= 0;
      else                       wait_cnt <= wait_cnt + 1;
   end

   // {mode, reg, byte, is_reg, ea, reg_after, pc_after}; regs start at 0x1000 + n*0x100
   localparam logic [55:0] VEC [16] = '{
      {3'd0, 3'd3, 1'b0, 1'b1, 16'h0003, 16'h1300, 16'h1700},
      {3'd1, 3'd2, 1'b0, 1'b0, 16'h1200, 16'h1200, 16'h1700},
      {3'd2, 3'd1, 1'b0, 1'b0, 16'h1100, 16'h1102, 16'h1700},
      {3'd2, 3'd1, 1'b1, 1'b0, 16'h1100, 16'h1101, 16'h1700},
      {3'd2, 3'd6, 1'b1, 1'b0, 16'h1600, 16'h1602, 16'h1700},
      {3'd2, 3'd7, 1'b1, 1'b0, 16'h1700, 16'h1702, 16'h1702},
      {3'd3, 3'd4, 1'b1, 1'b0, 16'h1500, 16'h1402, 16'h1700},
      {3'd4, 3'd5, 1'b0, 1'b0, 16'h14FE, 16'h14FE, 16'h1700},
      {3'd4, 3'd5, 1'b1, 1'b0, 16'h14FF, 16'h14FF, 16'h1700},
      {3'd4, 3'd6, 1'b1, 1'b0, 16'h15FE, 16'h15FE, 16'h1700},
      {3'd5, 3'd0, 1'b1, 1'b0, 16'h10FE, 16'h0FFE, 16'h1700},
      {3'd6, 3'd2, 1'b0, 1'b0, 16'h2A00, 16'h1200, 16'h1702},
      {3'd6, 3'd7, 1'b1, 1'b0, 16'h2F02, 16'h1702, 16'h1702},
      {3'd7, 3'd3, 1'b0, 1'b0, 16'h2C00, 16'h1300, 16'h1702},
      {3'd7, 3'd7, 1'b0, 1'b0, 16'h3002, 16'h1702, 16'h1702},
      {3'd3, 3'd7, 1'b0, 1'b0, 16'h1800, 16'h1702, 16'h1702}
   };

   function automatic string req_tag(input logic [2:0] m, input logic [2:0] r, input logic b);
      if (r == 3'd7 && (m == 3'd2 || m == 3'd3)) return "R7";
      case (m)
         3'd0: return "R1";
         3'd1: return "R2";
         3'd2, 3'd4: return b ? "R4" : "R3";
         3'd3, 3'd5: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic load_regs(input logic [15:0] base);
      for (int k = 0; k < 8; k++) init_vals[k] = base + (16'(k) << 8);
      @(negedge clk); init_req = 1'b1;
      @(negedge clk); init_req = 1'b0;
   endtask

   task automatic issue(input logic [2:0] m, input logic [2:0] r, input logic b);
      spec_mode = m; spec_reg = r; byte_op = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(output int reads, output bit timed_out);
      int cyc = 0;
      reads = 0;
      timed_out = 1'b0;
      while (!done && cyc < 200) begin
         if (mem_req && mem_ready) reads++;
         @(negedge clk);
         cyc++;
      end
      timed_out = !done;
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int  reads, exp_reads, others;
      bit  to;
      logic [15:0] hold_addr;

      repeat (3) @(negedge clk);
      check(!busy && !done && !mem_req && !rf_we, "R9", "reset outputs idle",
            {busy, done, mem_req, rf_we}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Table walk
      for (int i = 0; i < 16; i++) begin
         logic [2:0] m, r;
         logic       b;
         string      t;
         m = VEC[i][55:53]; r = VEC[i][52:50]; b = VEC[i][49];
         t = req_tag(m, r, b);
         lat = i % 3;
         load_regs(16'h1000);
         issue(m, r, b);
         check(busy, "R9", "busy after start", busy, 1);
         wait_done(reads, to);
         check(!to, t, "done arrives", to, 0);
         check(is_reg == VEC[i][48], t, "is_reg", is_reg, VEC[i][48]);
         check(ea == VEC[i][47:32], t, "ea", ea, VEC[i][47:32]);
         check(regs[r] == VEC[i][31:16], t, "register after", regs[r], VEC[i][31:16]);
         check(regs[7] == VEC[i][15:0], "R12", "pc after", regs[7], VEC[i][15:0]);
         others = 0;
         for (int k = 0; k < 7; k++)
            if (k != int'(r) && regs[k] != 16'h1000 + (16'(k) << 8)) others++;
         check(others == 0, "R12", "other registers untouched", others, 0);
         exp_reads = (m == 3'd3 || m == 3'd5 || m == 3'd6) ? 1 : (m == 3'd7) ? 2 : 0;
         check(reads == exp_reads, (m >= 3'd6) ? "R6" : (exp_reads > 0 ? "R5" : "R1"),
               "memory reads", reads, exp_reads);
         @(negedge clk);
         check(!done && !busy, "R9", "done single cycle", {done, busy}, 0);
      end

      // R8: wrap on pre-decrement from zero and post-increment past top
      lat = 0;
      load_regs(16'h0000);
      issue(3'd4, 3'd0, 1'b0);
      wait_done(reads, to);
      check(ea == 16'hFFFE && regs[0] == 16'hFFFE, "R8", "predec wrap", {ea, regs[0]}, 32'hFFFEFFFE);
      @(negedge clk);
      load_regs(16'hF0FF);
      issue(3'd2, 3'd0, 1'b1);
      wait_done(reads, to);
      check(ea == 16'hF0FF && regs[0] == 16'hF100, "R8", "postinc byte", {ea, regs[0]}, 32'hF0FFF100);
      @(negedge clk);
      load_regs(16'h1000);
      issue(3'd6, 3'd1, 1'b0);
      wait_done(reads, to);
      check(ea == 16'h2900, "R8", "index sum", ea, 16'h2900);
      @(negedge clk);

      // R10 and R11: stalled memory, start pulsed mid-sequence
      lat = 4;
      load_regs(16'h1000);
      issue(3'd7, 3'd3, 1'b0);
      check(mem_req == 1'b0, "R10", "no request in eval", mem_req, 0);
      @(negedge clk);
      hold_addr = mem_addr;
      check(mem_req && hold_addr == 16'h1700, "R10", "index fetch address", {15'd0, mem_req, hold_addr}, 32'h00011700);
      spec_mode = 3'd0; spec_reg = 3'd1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(mem_req && mem_addr == hold_addr, "R10", "address held while stalled", mem_addr, hold_addr);
      wait_done(reads, to);
      check(!is_reg && ea == 16'h2C00, "R11", "start ignored while busy", {is_reg, ea}, 17'h02C00);
      @(negedge clk);
      repeat (3) begin
         @(negedge clk);
         check(!done && !busy, "R11", "no extra sequence", {done, busy}, 0);
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule